// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a configuration image into an FPGA that takes its configuration over a slave SPI port. When the host issues a start command, the sequencer pulls the target's active-low reset low while holding chip select low. It then releases reset and checks that the target's done flag is still low. Next it waits out the target's internal housekeeping time with chip select held, and releases chip select. After that it streams the image bytes over SPI mode 0. Once the last byte has gone out, it checks that done has risen. It then sends a separate frame of zero bytes that starts the loaded design.

The host hands in a start pulse, with a flag marking a partial-reconfiguration request, and then the image one byte at a time over a valid/ready handshake. The host marks the final byte with a last flag. The block reports busy while a run is in progress. When the run ends it holds a success flag and a 2-bit result code until the next start. All delays are derived from the system clock frequency parameter. The serial clock is the system clock divided by 2·SCK_DIV. Elaboration stops with an error when the resulting serial clock lies outside 1 MHz to 25 MHz.

Top module: `spi_cfg_loader`

## Requirements
- R1: After reset, chip select is high, serial clock low, target reset high, busy low, ready low, success low and the result code 0 (ok).
- R2: A start without the partial flag drives the target reset and chip select low together. Reset stays low for exactly CLK_HZ/1e6 · RESET_US clock cycles, and rises while chip select is still low.
- R3: The done input passes through a SYNC_STAGES flip-flop synchroniser and is judged on the (SYNC_STAGES+2)-th cycle after reset rises. If it is high, the run ends with result code 1 (reset failure) and chip select rises right then. No serial clock edge occurs in that run.
- R4: When done is low at that check, chip select stays low for exactly SYNC_STAGES+2 + CLK_HZ/1e6 · HOUSE_US cycles after reset rises. It then goes high for 2·SCK_DIV cycles before the data frame begins.
- R5: Image bytes go out in one chip-select frame, most significant bit first, in SPI mode 0. The serial clock idles low and each clock phase lasts SCK_DIV cycles. Data changes only while the clock is low, and the serial clock never runs while chip select is high.
- R6: Ready is high only inside the data frame while the shifter is empty and before the last byte has been accepted. Exactly one byte is taken per valid-and-ready cycle, and ready drops in the cycle after each accepted byte.
- R7: After the last byte has been shifted out, chip select rises and done is judged SYNC_STAGES+2 cycles later. If it is low, the run ends with result code 2 (not done), success stays low and no further frame is sent.
- R8: If done is high at that check, a new frame of PAD_BYTES zero bytes follows (56 zero bits by default). After it, busy falls, success is high and the result code is 0.
- R9: A start with the partial flag set returns result code 3 (unsupported) on the next cycle. The reset, chip select and serial clock pins do not move, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start command, taken only when idle |
| partial_i | input | 1 | Start requests partial reconfiguration |
| s_valid_i | input | 1 | Image byte valid |
| s_data_i | input | 8 | Image byte |
| s_last_i | input | 1 | Marks the final image byte |
| s_ready_o | output | 1 | Sequencer can take an image byte |
| busy_o | output | 1 | A configuration run is in progress |
| success_o | output | 1 | Last run completed with done high and activation sent |
| status_o | output | 2 | Result: 0 ok, 1 reset failure, 2 not done, 3 unsupported |
| tgt_rst_n_o | output | 1 | Active-low reset to the target |
| spi_cs_n_o | output | 1 | Active-low chip select |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to the target |
| tgt_done_i | input | 1 | Target configuration-done flag, asynchronous |

## Verification
The result code of a refused partial request is due one clock after the start pulse. The bench reads it at the following falling edge. Every other result appears only at the end of a run, so the bench waits on the falling edge where busy drops and reads the result there. The pin timing is measured by a monitor that samples all pins on every falling clock edge, halfway between register updates. It counts reset-low cycles, chip-select-low cycles after reset release, and clock-high cycles per bit. Each count is compared with the exact values that R2, R4 and R5 derive from the clock frequency and divider.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

   typedef enum logic [1:0] {
      CFG_OK          = 2'd0,
      CFG_RST_FAIL    = 2'd1,
      CFG_NOT_DONE    = 2'd2,
      CFG_UNSUPPORTED = 2'd3
   } cfg_status_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RST,
      S_CHK_LO,
      S_HOUSE,
      S_GAP,
      S_STREAM,
      S_CHK_HI,
      S_PAD
   } cfg_state_e;

   function automatic int unsigned us_to_cycles(input int unsigned clk_hz,
                                                input int unsigned us);
      return (clk_hz / 1_000_000) * us;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_cfg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= '0;
      else        ff_q <= {ff_q[STAGES-2:0], d_i};
   end

   assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/spi_cfg_timer.sv
module spi_cfg_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load_i)       cnt_q <= val_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/spi_cfg_shift.sv
module spi_cfg_shift #(
   parameter int unsigned DIV = 4,
   parameter int unsigned W   = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] data_i,
   output logic         busy_o,
   output logic         sck_o,
   output logic         mosi_o
);
   localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam int unsigned BW = $clog2(W);

   if (DIV < 1) begin : g_bad_div
      $error("spi_cfg_shift: DIV must be at least 1");
   end
   if (W < 2) begin : g_bad_w
      $error("spi_cfg_shift: W must be at least 2");
   end

   logic [W-1:0]  sr_q;
   logic [DW-1:0] div_q;
   logic [BW-1:0] bit_q;
   logic          sck_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         div_q  <= '0;
         bit_q  <= '0;
         sck_q  <= 1'b0;
         busy_q <= 1'b0;
      end else if (load_i) begin
         sr_q   <= data_i;
         div_q  <= '0;
         bit_q  <= '0;
         sck_q  <= 1'b0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (div_q == DW'(DIV - 1)) begin
            div_q <= '0;
            if (!sck_q) begin
               sck_q <= 1'b1;
            end else begin
               sck_q <= 1'b0;
               if (bit_q == BW'(W - 1)) begin
                  busy_q <= 1'b0;
               end else begin
                  bit_q <= bit_q + 1'b1;
                  sr_q  <= {sr_q[W-2:0], 1'b0};
               end
            end
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
   end

   assign busy_o = busy_q;
   assign sck_o  = sck_q;
   assign mosi_o = sr_q[W-1] & busy_q;

   // R5: data held steady for the whole high phase of the serial clock
   assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_q && $past(sck_q)) |-> $stable(mosi_o));

   // R6: a byte is only loaded into an empty shifter
   assert_load_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !busy_q);
endmodule

// File: rtl/spi_cfg_loader.sv
module spi_cfg_loader
   import spi_cfg_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 125_000_000,
   parameter int unsigned SCK_DIV     = 4,
   parameter int unsigned RESET_US    = 1,
   parameter int unsigned HOUSE_US    = 1200,
   parameter int unsigned PAD_BYTES   = 7,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       partial_i,
   input  logic       s_valid_i,
   input  logic [7:0] s_data_i,
   input  logic       s_last_i,
   output logic       s_ready_o,
   output logic       busy_o,
   output logic       success_o,
   output logic [1:0] status_o,
   output logic       tgt_rst_n_o,
   output logic       spi_cs_n_o,
   output logic       spi_sck_o,
   output logic       spi_mosi_o,
   input  logic       tgt_done_i
);
   localparam int unsigned RST_CYC    = us_to_cycles(CLK_HZ, RESET_US);
   localparam int unsigned HOUSE_CYC  = us_to_cycles(CLK_HZ, HOUSE_US);
   localparam int unsigned SETTLE_CYC = SYNC_STAGES + 2;
   localparam int unsigned GAP_CYC    = 2 * SCK_DIV;
   localparam int unsigned SCK_HZ     = CLK_HZ / (2 * SCK_DIV);
   localparam int unsigned MAX_CYC    = umax(umax(RST_CYC, HOUSE_CYC),
                                             umax(SETTLE_CYC, GAP_CYC));
   localparam int unsigned TW         = $clog2(MAX_CYC + 1);
   localparam int unsigned PW         = $clog2(PAD_BYTES + 1);

   if (SCK_DIV < 1 || SCK_HZ < 1_000_000 || SCK_HZ > 25_000_000) begin : g_bad_sck
      $error("spi_cfg_loader: serial clock outside 1..25 MHz");
   end
   if (RST_CYC < 1 || HOUSE_CYC < 1) begin : g_bad_delay
      $error("spi_cfg_loader: CLK_HZ too low for the reset and housekeeping delays");
   end
   if (PAD_BYTES * 8 < 49) begin : g_bad_pad
      $error("spi_cfg_loader: activation padding must cover at least 49 bits");
   end

   cfg_state_e    state_q, state_d;
   cfg_status_e   status_q, status_d;
   logic          ok_q, ok_d;
   logic          last_q, last_d;
   logic [PW-1:0] pad_q, pad_d;

   logic          tmr_load, tmr_zero;
   logic [TW-1:0] tmr_val;
   logic          sh_load, sh_busy;
   logic [7:0]    sh_data;
   logic          done_s;

   spi_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(tgt_done_i), .q_o(done_s)
   );

   spi_cfg_timer #(.W(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
   );

   spi_cfg_shift #(.DIV(SCK_DIV), .W(8)) u_shift (
      .clk(clk), .rst_n(rst_n), .load_i(sh_load), .data_i(sh_data),
      .busy_o(sh_busy), .sck_o(spi_sck_o), .mosi_o(spi_mosi_o)
   );

   assign s_ready_o = (state_q == S_STREAM) && !sh_busy && !last_q;

   always_comb begin
      state_d  = state_q;
      status_d = status_q;
      ok_d     = ok_q;
      last_d   = last_q;
      pad_d    = pad_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      sh_load  = 1'b0;
      sh_data  = '0;
      unique case (state_q)
         S_IDLE: if (start_i) begin
            ok_d = 1'b0;
            if (partial_i) begin
               status_d = CFG_UNSUPPORTED;
            end else begin
               status_d = CFG_OK;
               state_d  = S_RST;
               tmr_load = 1'b1;
               tmr_val  = TW'(RST_CYC - 1);
            end
         end
         S_RST: if (tmr_zero) begin
            state_d  = S_CHK_LO;
            tmr_load = 1'b1;
            tmr_val  = TW'(SETTLE_CYC - 1);
         end
         S_CHK_LO: if (tmr_zero) begin
            if (done_s) begin
               status_d = CFG_RST_FAIL;
               state_d  = S_IDLE;
            end else begin
               state_d  = S_HOUSE;
               tmr_load = 1'b1;
               tmr_val  = TW'(HOUSE_CYC - 1);
            end
         end
         S_HOUSE: if (tmr_zero) begin
            state_d  = S_GAP;
            tmr_load = 1'b1;
            tmr_val  = TW'(GAP_CYC - 1);
         end
         S_GAP: if (tmr_zero) begin
            state_d = S_STREAM;
            last_d  = 1'b0;
         end
         S_STREAM: begin
            if (s_valid_i && s_ready_o) begin
               sh_load = 1'b1;
               sh_data = s_data_i;
               if (s_last_i) last_d = 1'b1;
            end else if (last_q && !sh_busy) begin
               state_d  = S_CHK_HI;
               tmr_load = 1'b1;
               tmr_val  = TW'(SETTLE_CYC - 1);
            end
         end
         S_CHK_HI: if (tmr_zero) begin
            if (done_s) begin
               state_d = S_PAD;
               pad_d   = '0;
            end else begin
               status_d = CFG_NOT_DONE;
               state_d  = S_IDLE;
            end
         end
         S_PAD: if (!sh_busy) begin
            if (pad_q != PW'(PAD_BYTES)) begin
               sh_load = 1'b1;
               pad_d   = pad_q + 1'b1;
            end else begin
               ok_d    = 1'b1;
               state_d = S_IDLE;
            end
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         status_q <= CFG_OK;
         ok_q     <= 1'b0;
         last_q   <= 1'b0;
         pad_q    <= '0;
      end else begin
         state_q  <= state_d;
         status_q <= status_d;
         ok_q     <= ok_d;
         last_q   <= last_d;
         pad_q    <= pad_d;
      end
   end

   always_comb begin
      unique case (state_q)
         S_RST, S_CHK_LO, S_HOUSE, S_STREAM, S_PAD: spi_cs_n_o = 1'b0;
         default:                                   spi_cs_n_o = 1'b1;
      endcase
   end

   assign tgt_rst_n_o = (state_q != S_RST);
   assign busy_o      = (state_q != S_IDLE);
   assign success_o   = ok_q;
   assign status_o    = status_q;

   // R5: the serial clock only runs inside a chip-select frame
   assert_sck_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sck_o |-> !spi_cs_n_o);

   // R2: target reset is only low while chip select is low
   assert_rst_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt_rst_n_o |-> !spi_cs_n_o);

   // R3: done high after reset release ends the run with a reset failure
   assert_reset_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_CHK_LO && tmr_zero && done_s) |=>
         (status_o == 2'd1 && spi_cs_n_o && !busy_o));

   // R6: one byte per handshake, ready drops after acceptance
   assert_one_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid_i && s_ready_o) |=> !s_ready_o);

   // R7: done still low after the image ends the run without padding
   assert_not_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_CHK_HI && tmr_zero && !done_s) |=>
         (status_o == 2'd2 && !success_o && !busy_o));

   // R9: a partial request is refused and leaves the pins alone
   assert_partial_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && partial_i) |=>
         (status_o == 2'd3 && spi_cs_n_o && tgt_rst_n_o && !busy_o));
endmodule

// File: tb/tb_spi_cfg_loader.sv
module tb_spi_cfg_loader;
   localparam int unsigned CLK_HZ    = 8_000_000;
   localparam int unsigned DIV       = 2;
   localparam int unsigned RST_EXP   = CLK_HZ / 1_000_000 * 1;
   localparam int unsigned HOUSE_EXP = CLK_HZ / 1_000_000 * 1200;
   localparam int unsigned SETTLE    = 2 + 2;
   localparam int unsigned PADB      = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, partial_i = 1'b0;
   logic       s_valid_i = 1'b0, s_last_i = 1'b0;
   logic [7:0] s_data_i = 8'h00;
   logic       tgt_done_i = 1'b0;
   logic       s_ready_o, busy_o, success_o, tgt_rst_n_o, spi_cs_n_o, spi_sck_o, spi_mosi_o;
   logic [1:0] status_o;

   always #4ns clk = ~clk;

   spi_cfg_loader #(.CLK_HZ(CLK_HZ), .SCK_DIV(DIV), .RESET_US(1), .HOUSE_US(1200),
                    .PAD_BYTES(PADB), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
      .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_last_i(s_last_i),
      .s_ready_o(s_ready_o), .busy_o(busy_o), .success_o(success_o),
      .status_o(status_o), .tgt_rst_n_o(tgt_rst_n_o), .spi_cs_n_o(spi_cs_n_o),
      .spi_sck_o(spi_sck_o), .spi_mosi_o(spi_mosi_o), .tgt_done_i(tgt_done_i)
   );

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   // monitor state
   logic       p_sck = 1'b0, p_mosi = 1'b0;
   int         bitn, fr_bits, fr_house, rst_lo, sck_out, mosi_chg, hi_cnt, tot_bits;
   int         ready_bad, ready_after_last;
   bit         last_sent;
   logic [7:0] shreg;
   logic [7:0] cap[$];
   int         fbits[$];
   int         fhouse[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic clear_mon();
      bitn = 0; fr_bits = 0; fr_house = 0; rst_lo = 0; sck_out = 0; mosi_chg = 0;
      hi_cnt = 0; tot_bits = 0; ready_bad = 0; ready_after_last = 0; last_sent = 1'b0;
      cap.delete(); fbits.delete(); fhouse.delete();
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (!tgt_rst_n_o) rst_lo++;
         if (spi_cs_n_o && spi_sck_o) sck_out++;
         if (spi_cs_n_o && s_ready_o) ready_bad++;
         if (last_sent && s_ready_o) ready_after_last++;
         if (!spi_cs_n_o) begin
            if (tgt_rst_n_o) fr_house++;
            if (spi_sck_o) hi_cnt++;
            if (spi_sck_o && !p_sck) begin
               shreg = {shreg[6:0], spi_mosi_o};
               bitn++; fr_bits++; tot_bits++;
               if (bitn == 8) begin cap.push_back(shreg); bitn = 0; end
            end
            if (spi_sck_o && p_sck && spi_mosi_o != p_mosi) mosi_chg++;
         end
         if (!p_cs_n_seen && spi_cs_n_o) begin
            fbits.push_back(fr_bits); fhouse.push_back(fr_house);
            fr_bits = 0; fr_house = 0;
         end
      end
      p_sck = spi_sck_o;
      p_mosi = spi_mosi_o;
      p_cs_n_seen = spi_cs_n_o;
   end
   logic p_cs_n_seen = 1'b1;

   task automatic step();
      @(negedge clk); #1ns;
   endtask

   task automatic pulse_start(input bit part);
      step();
      start_i = 1'b1; partial_i = part;
      @(posedge clk); #1ns;
      start_i = 1'b0; partial_i = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      @(negedge clk);
      while (busy_o && n < 40000) begin @(negedge clk); n++; end
      if (busy_o) begin
         chk(1'b0, "watchdog", n, 40000);
         summary();
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input bit last, input int gap);
      int n = 0;
      for (int g = 0; g < gap; g++) step();
      s_data_i = b; s_last_i = last; s_valid_i = 1'b1;
      while (!s_ready_o && n < 40000) begin step(); n++; end
      @(posedge clk); #1ns;
      s_valid_i = 1'b0; s_last_i = 1'b0;
      if (last) last_sent = 1'b1;
   endtask

   task automatic run_image(input logic [7:0] img[], input bit done_at_end, input int gap);
      int n = 0;
      clear_mon();
      tgt_done_i = 1'b0;
      pulse_start(1'b0);
      while (spi_cs_n_o == 1'b0 || tgt_rst_n_o == 1'b0 || fbits.size() == 0) begin
         step(); n++;
         if (n > 40000) break;
      end
      foreach (img[i]) send_byte(img[i], i == img.size() - 1, gap);
      if (done_at_end) tgt_done_i = 1'b1;
      wait_idle();
      step();
   endtask

   initial begin
      #(64'd190000 * 8ns);
      chk(1'b0, "watchdog", 0, 1);
      summary();
   end

   initial begin
      logic [7:0] img_a[] = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81};
      logic [7:0] img_b[] = '{8'h01, 8'h80, 8'h7E};
      logic [7:0] img_c[] = '{8'hC3, 8'h5A};
      clear_mon();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(spi_cs_n_o == 1'b1, "R1 cs_n", spi_cs_n_o, 1);
      chk(spi_sck_o == 1'b0, "R1 sck", spi_sck_o, 0);
      chk(tgt_rst_n_o == 1'b1, "R1 tgt_rst_n", tgt_rst_n_o, 1);
      chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
      chk(s_ready_o == 1'b0, "R1 ready", s_ready_o, 0);
      chk(success_o == 1'b0, "R1 success", success_o, 0);
      chk(status_o == 2'd0, "R1 status", status_o, 0);

      // R9 partial request refused
      clear_mon();
      pulse_start(1'b1);
      @(negedge clk);
      chk(status_o == 2'd3, "R9 status", status_o, 3);
      chk(busy_o == 1'b0, "R9 busy", busy_o, 0);
      repeat (20) @(negedge clk);
      chk(fbits.size() == 0, "R9 frames", fbits.size(), 0);
      chk(rst_lo == 0, "R9 reset pin", rst_lo, 0);
      chk(tot_bits == 0 && sck_out == 0, "R9 sck", tot_bits, 0);

      // R3 reset failure: done already high
      clear_mon();
      tgt_done_i = 1'b1;
      pulse_start(1'b0);
      wait_idle();
      step();
      chk(status_o == 2'd1, "R3 status", status_o, 1);
      chk(success_o == 1'b0, "R3 success", success_o, 0);
      chk(fbits.size() == 1, "R3 frames", fbits.size(), 1);
      if (fhouse.size() > 0)
         chk(fhouse[0] == SETTLE, "R3 cs low after release", fhouse[0], SETTLE);
      chk(tot_bits == 0, "R3 no sck", tot_bits, 0);
      chk(rst_lo == RST_EXP, "R2 reset width", rst_lo, RST_EXP);

      // R2 R4 R5 R6 R8 full image
      run_image(img_a, 1'b1, 0);
      chk(status_o == 2'd0, "R8 status", status_o, 0);
      chk(success_o == 1'b1, "R8 success", success_o, 1);
      chk(rst_lo == RST_EXP, "R2 reset width", rst_lo, RST_EXP);
      chk(fbits.size() == 3, "R8 frame count", fbits.size(), 3);
      if (fbits.size() == 3) begin
         chk(fhouse[0] == SETTLE + HOUSE_EXP, "R4 housekeeping", fhouse[0], SETTLE + HOUSE_EXP);
         chk(fbits[0] == 0, "R4 no data in reset frame", fbits[0], 0);
         chk(fbits[1] == 8 * img_a.size(), "R5 data bits", fbits[1], 8 * img_a.size());
         chk(fbits[2] == 8 * PADB, "R8 pad bits", fbits[2], 8 * PADB);
      end
      chk(cap.size() == img_a.size() + PADB, "R5 byte count", cap.size(), img_a.size() + PADB);
      if (cap.size() == img_a.size() + PADB) begin
         foreach (img_a[i]) chk(cap[i] == img_a[i], "R5 byte msb-first", cap[i], img_a[i]);
         for (int i = 0; i < PADB; i++)
            chk(cap[img_a.size() + i] == 8'h00, "R8 pad zero", cap[img_a.size() + i], 0);
      end
      chk(hi_cnt == tot_bits * DIV, "R5 clock high phase", hi_cnt, tot_bits * DIV);
      chk(mosi_chg == 0, "R5 data stable while high", mosi_chg, 0);
      chk(sck_out == 0, "R5 sck outside frame", sck_out, 0);
      chk(ready_bad == 0, "R6 ready outside frame", ready_bad, 0);
      chk(ready_after_last == 0, "R6 ready after last", ready_after_last, 0);

      // R7 done never rises
      run_image(img_b, 1'b0, 0);
      chk(status_o == 2'd2, "R7 status", status_o, 2);
      chk(success_o == 1'b0, "R7 success", success_o, 0);
      chk(fbits.size() == 2, "R7 no pad frame", fbits.size(), 2);
      chk(cap.size() == img_b.size(), "R7 byte count", cap.size(), img_b.size());

      // R6 R8 image with idle gaps on the host side
      run_image(img_c, 1'b1, 5);
      chk(status_o == 2'd0 && success_o == 1'b1, "R8 gapped run", status_o, 0);
      chk(cap.size() == img_c.size() + PADB, "R6 gapped byte count", cap.size(), img_c.size() + PADB);
      if (cap.size() >= 2) begin
         chk(cap[0] == img_c[0], "R6 gapped byte0", cap[0], img_c[0]);
         chk(cap[1] == img_c[1], "R6 gapped byte1", cap[1], img_c[1]);
      end
      chk(ready_after_last == 0, "R6 gapped ready after last", ready_after_last, 0);
      summary();
   end
endmodule